// File: doc/BRIEF.md
# Two-Pass Multi-Level Cell Program Sequencer

This block sits on the controller side of a two-bit-per-cell flash array and sequences the programming of one word line at a time. Each page program is a closed loop: one program pulse, then one verify, repeated until enough cells of the page have reached their target level, or until a pulse budget runs out. The cell array itself is modelled outside the block: it sees the pulse strobe and the per-cell target levels, and it answers verify and read requests with one bit per cell.

A word line is written in two ordered passes. The lower-page pass leaves a cell erased or lifts it to an intermediate level. The upper-page pass first spends one cycle on an internal read, which recovers every cell's lower bit from the array. It then drives each cell to its final level from the upper and lower bits together. An upper-page command on a word line whose lower page has not been written is refused. A `busy` flag covers the whole operation. A one-cycle `done` reports the end, and `fail` tells a budget overrun from a pass.

Top module: `mlc_prog_seq`

## Requirements
- R1: After reset the block is idle with `busy`, `done`, `fail`, `err`, `pgm_pulse`, `vfy_req` and `rd_req` low and `step_idx` zero, and every word line counts as having no lower page written.
- R2: During a lower-page pass, cell i's target code on `tgt_lvl[2i+1:2i]` is 0 (erased) when its data bit is 1 and 2 (intermediate) when its data bit is 0.
- R3: Each `pgm_pulse` cycle is followed by exactly one `vfy_req` cycle, and the pulse/verify loop repeats until the verify passes. The operation then ends with `done` and `fail` low.
- R4: A verify passes when at least PASS_MIN of the `vfy_bits` (1 = cell reached its target) are set, even if some cells never reach their target.
- R5: An upper-page pass begins with exactly one `rd_req` cycle, before its first pulse, and takes `rd_bits` (1 = cell below the intermediate level, so lower bit 1) as the lower-page data. A lower-page pass issues no read.
- R6: During an upper-page pass the target code for cell i comes from {upper bit, lower bit} in ascending threshold order: 11 gives 0, 01 gives 1, 00 gives 2 and 10 gives 3.
- R7: If the verify after pulse number MAX_PULSES still fails, the operation ends with `done` and `fail` high. A failed lower pass does not mark its word line as written.
- R8: `step_idx` is 0 during the first pulse of each pass and rises by one with every pulse, so at `done` it equals the number of pulses given in that pass.
- R9: An upper-page command for a word line with no written lower page raises `err` for one cycle, leaves `busy` low and issues no pulse or read.
- R10: `busy` is high from the cycle after a command is accepted until the operation ends. A command presented while busy is ignored.
- R11: `done` is high for exactly one cycle per finished operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_upper | input | 1 | Page select: 0 lower page, 1 upper page |
| cmd_wl | input | WL_W | Word line address |
| cmd_data | input | CELLS | Page data, one bit per cell |
| rd_bits | input | CELLS | Internal read result, 1 = cell below the intermediate level |
| vfy_bits | input | CELLS | Verify result, 1 = cell at or above its target |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| fail | output | 1 | Pulse budget exhausted, valid with `done` |
| err | output | 1 | One-cycle command rejection strobe |
| rd_req | output | 1 | Internal read request |
| pgm_pulse | output | 1 | Program pulse strobe |
| vfy_req | output | 1 | Verify request |
| act_wl | output | WL_W | Word line being programmed |
| step_idx | output | STEP_W | Programming step index |
| tgt_lvl | output | 2*CELLS | Target level code per cell, two bits each |

## Verification
The bench builds the block with eight cells, a pass threshold of six, a budget of eight pulses and four word lines. With eight cells, stuck cells in the array model make majority passes and hopeless loops both easy to set up. The short budget lets a word line with three stuck cells run into the fail exit within a few dozen cycles. A model step of three pulses per level makes lower passes take six pulses and upper passes three, so the restart of the step index between passes shows at every `done`.

// File: rtl/mlc_prog_seq.sv
module mlc_prog_seq #(
  parameter int CELLS      = 16,
  parameter int PASS_MIN   = 14,
  parameter int MAX_PULSES = 24,
  parameter int WL_COUNT   = 64,
  localparam int WL_W   = $clog2(WL_COUNT),
  localparam int STEP_W = $clog2(MAX_PULSES + 1),
  localparam int CNT_W  = $clog2(CELLS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_upper,
  input  logic [WL_W-1:0]    cmd_wl,
  input  logic [CELLS-1:0]   cmd_data,
  input  logic [CELLS-1:0]   rd_bits,
  input  logic [CELLS-1:0]   vfy_bits,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic               err,
  output logic               rd_req,
  output logic               pgm_pulse,
  output logic               vfy_req,
  output logic [WL_W-1:0]    act_wl,
  output logic [STEP_W-1:0]  step_idx,
  output logic [2*CELLS-1:0] tgt_lvl
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_PULSE, S_VFY} state_t;

  state_t              st;
  logic                upper_r;
  logic [CELLS-1:0]    dat_r;
  logic [CELLS-1:0]    lp_r;
  logic [WL_COUNT-1:0] lp_done;
  logic [CNT_W-1:0]    pass_cnt;

  assign busy      = (st != S_IDLE);
  assign rd_req    = (st == S_READ);
  assign pgm_pulse = (st == S_PULSE);
  assign vfy_req   = (st == S_VFY);

  always_comb begin
    pass_cnt = '0;
    for (int i = 0; i < CELLS; i++) pass_cnt = pass_cnt + CNT_W'(vfy_bits[i]);
  end

  wire verify_ok  = pass_cnt >= CNT_W'(PASS_MIN);
  wire budget_out = step_idx == STEP_W'(MAX_PULSES);

  for (genvar i = 0; i < CELLS; i++) begin : g_tgt
    wire lb = lp_r[i];
    wire ub = dat_r[i];
    assign tgt_lvl[2*i +: 2] = !upper_r ? (lb ? 2'd0 : 2'd2)
                             : lb       ? (ub ? 2'd0 : 2'd1)
                                        : (ub ? 2'd3 : 2'd2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      upper_r  <= 1'b0;
      dat_r    <= '0;
      lp_r     <= '0;
      lp_done  <= '0;
      act_wl   <= '0;
      step_idx <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (cmd_upper && !lp_done[cmd_wl]) begin
            err <= 1'b1;
          end else begin
            upper_r  <= cmd_upper;
            act_wl   <= cmd_wl;
            dat_r    <= cmd_data;
            step_idx <= '0;
            fail     <= 1'b0;
            if (!cmd_upper) lp_r <= cmd_data;
            st <= cmd_upper ? S_READ : S_PULSE;
          end
        end
        S_READ: begin
          lp_r <= rd_bits;
          st   <= S_PULSE;
        end
        S_PULSE: begin
          step_idx <= step_idx + 1'b1;
          st       <= S_VFY;
        end
        S_VFY: begin
          if (verify_ok) begin
            done <= 1'b1;
            st   <= S_IDLE;
            if (!upper_r) lp_done[act_wl] <= 1'b1;
          end else if (budget_out) begin
            done <= 1'b1;
            fail <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_PULSE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mlc_prog_seq_chk.sv
module mlc_prog_seq_chk #(
  parameter int STEP_W     = 5,
  parameter int MAX_PULSES = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              rd_req,
  input logic              pgm_pulse,
  input logic              vfy_req,
  input logic [STEP_W-1:0] step_idx
);

  p_pulse_then_vfy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_pulse |=> vfy_req);

  p_read_then_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> pgm_pulse);

  p_first_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_pulse && !$past(vfy_req)) |-> step_idx == '0);

  p_step_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_pulse && $past(vfy_req)) |-> step_idx == STEP_W'($past(step_idx, 2) + 1'b1));

  p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_pulse |-> step_idx < STEP_W'(MAX_PULSES));

  p_reject_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_pulse || vfy_req || rd_req) |-> busy);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mlc_prog_seq mlc_prog_seq_chk #(.STEP_W(STEP_W), .MAX_PULSES(MAX_PULSES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .rd_req(rd_req), .pgm_pulse(pgm_pulse), .vfy_req(vfy_req), .step_idx(step_idx)
);

// File: tb/test_mlc_prog_seq.sv
module test_mlc_prog_seq;
  localparam int CELLS = 8, PASS_MIN = 6, MAX_PULSES = 8, WL_COUNT = 4;
  localparam int WL_W = 2, STEP_W = 4, K = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_upper = 0;
  logic [WL_W-1:0] cmd_wl = '0;
  logic [CELLS-1:0] cmd_data = '0, rd_bits, vfy_bits;
  logic busy, done, fail, err, rd_req, pgm_pulse, vfy_req;
  logic [WL_W-1:0] act_wl;
  logic [STEP_W-1:0] step_idx;
  logic [2*CELLS-1:0] tgt_lvl;

  always #2 clk = ~clk;

  mlc_prog_seq #(.CELLS(CELLS), .PASS_MIN(PASS_MIN), .MAX_PULSES(MAX_PULSES), .WL_COUNT(WL_COUNT))
  i_mlc_prog_seq (.*);

  int thr [WL_COUNT][CELLS];
  logic [CELLS-1:0] stuck = '0;
  int pulse_tot = 0, rd_tot = 0, err_tot = 0;
  int total = 0, bad = 0;
  logic finished = 0;
  logic [CELLS-1:0] lower_dat [WL_COUNT];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WL_COUNT; w++)
        for (int i = 0; i < CELLS; i++) thr[w][i] <= 0;
    end else if (pgm_pulse) begin
      for (int i = 0; i < CELLS; i++)
        if (!stuck[i] && thr[act_wl][i] < K * int'(tgt_lvl[2*i +: 2]))
          thr[act_wl][i] <= thr[act_wl][i] + 1;
    end
    if (pgm_pulse) pulse_tot <= pulse_tot + 1;
    if (rd_req)    rd_tot    <= rd_tot + 1;
    if (err)       err_tot   <= err_tot + 1;
  end

  always_comb begin
    for (int i = 0; i < CELLS; i++) begin
      vfy_bits[i] = thr[act_wl][i] >= K * int'(tgt_lvl[2*i +: 2]);
      rd_bits[i]  = thr[act_wl][i] < 2 * K;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // upper, wl, data, stuck, pulses, fail, err
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'hF0, 8'h00, 4'd6, 1'b0, 1'b0},
    {1'b1, 2'd0, 8'hCC, 8'h00, 4'd3, 1'b0, 1'b0},
    {1'b0, 2'd1, 8'hFF, 8'h00, 4'd1, 1'b0, 1'b0},
    {1'b1, 2'd1, 8'h00, 8'h00, 4'd3, 1'b0, 1'b0},
    {1'b1, 2'd2, 8'h5A, 8'h00, 4'd0, 1'b0, 1'b1},
    {1'b0, 2'd2, 8'h00, 8'h07, 4'd8, 1'b1, 1'b0},
    {1'b0, 2'd3, 8'h00, 8'h03, 4'd6, 1'b0, 1'b0},
    {1'b1, 2'd2, 8'h00, 8'h00, 4'd0, 1'b0, 1'b1}
  };

  task automatic run_op(input bit up, input int wl, input logic [7:0] dat,
                        output int np, output int nr, output int ne, output bit got_done);
    int p0, r0, e0, n;
    p0 = pulse_tot; r0 = rd_tot; e0 = err_tot;
    cmd_upper = up; cmd_wl = WL_W'(wl); cmd_data = dat; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    n = 0;
    while (!done && !err && n < 200) begin @(negedge clk); n++; end
    got_done = done;
    @(negedge clk);
    np = pulse_tot - p0; nr = rd_tot - r0; ne = err_tot - e0;
  endtask

  function automatic int exp_lvl(bit up, bit ub, bit lb);
    if (!up) return lb ? 0 : 2;
    return lb ? (ub ? 0 : 1) : (ub ? 3 : 2);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !fail && !err && !pgm_pulse && !vfy_req && !rd_req && step_idx == 0,
          "R1 reset", {busy, done, fail, err}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [24:0] e;
      int np, nr, ne, lvl_bad;
      bit gd, fl;
      logic [3:0] stp;
      e = VEC[v];
      stuck = e[13:6];
      run_op(e[24], int'(e[23:22]), e[21:14], np, nr, ne, gd);
      fl = fail; stp = step_idx;
      if (e[0]) begin
        check(ne == 1 && np == 0 && nr == 0 && !gd, "R9 reject", np, 0);
      end else begin
        check(np == int'(e[5:2]), e[24] ? "R3 R6 upper pulses" : "R3 R4 lower pulses", np, int'(e[5:2]));
        check(fl == e[1], "R7 fail flag", fl, e[1]);
        check(stp == e[5:2], "R8 step index at done", stp, e[5:2]);
        check(nr == (e[24] ? 1 : 0), "R5 internal read count", nr, e[24]);
        if (!e[1]) begin
          lvl_bad = 0;
          for (int i = 0; i < CELLS; i++) begin
            int x;
            x = exp_lvl(e[24], e[14+i], e[24] ? lower_dat[e[23:22]][i] : e[14+i]);
            if (!stuck[i] && thr[e[23:22]][i] != K * x) lvl_bad++;
          end
          check(lvl_bad == 0, e[24] ? "R6 final levels" : "R2 R4 intermediate levels", lvl_bad, 0);
          if (!e[24]) lower_dat[e[23:22]] = e[21:14];
        end
      end
    end

    // R10: command while busy is ignored; R11 single done
    begin
      int np, nr, ne, n, dn, p0, e0;
      stuck = '0;
      p0 = pulse_tot; e0 = err_tot;
      cmd_upper = 0; cmd_wl = 2'd2; cmd_data = 8'h00; cmd_valid = 1;
      @(negedge clk); cmd_valid = 0;
      check(busy, "R10 busy after accept", busy, 1);
      repeat (2) @(negedge clk);
      cmd_upper = 1; cmd_wl = 2'd3; cmd_data = 8'hFF; cmd_valid = 1;
      @(negedge clk); cmd_valid = 0;
      n = 0; dn = 0;
      while (busy && n < 200) begin @(negedge clk); n++; end
      repeat (3) begin dn += done; @(negedge clk); end
      np = pulse_tot - p0; ne = err_tot - e0;
      check(np == 6 && ne == 0, "R10 busy command ignored", np, 6);
      check(dn == 1, "R11 single done", dn, 1);
    end

    // R1: reset forgets written lower pages
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    begin
      int np, nr, ne; bit gd;
      run_op(1, 0, 8'h00, np, nr, ne, gd);
      check(ne == 1 && np == 0, "R1 R9 reject after reset", ne, 1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule